// File: doc/BRIEF.md
# Bank-Selected Round, Window and Clamp Output Stage

This block turns the wide accumulator result of a filter into a narrow output sample. On every clock a bank index picks one entry from each of three sixteen-entry register files. The first file holds a rounding constant, which is added to the accumulator. The second holds a window position, which picks twelve contiguous bits out of the sum. The third holds a pair of limits, which clamp the windowed value when clamping is enabled.

The bank index may change on every cycle. Each stream of an interleaved data set can therefore have its own rounding, scaling and range. The index and the entries it selects travel down the pipeline with the data. A sample always uses the settings that were in force on its own input cycle, even if software rewrites an entry while that sample is still in the pipeline.

All three register files, and the clamp-enable bit, are loaded through one address/data write port. A build-time parameter selects either the vertical-path address map or the horizontal-path address map.

Top module: `rcw_output_stage`

## Requirements
- R1: The selected 32-bit round value is added, modulo 2^32, to `acc_i` before any bit selection.
- R2: `bank_sel_i` value n selects round entry n, window entry n and limit entry n together, and it may take a different value on every cycle.
- R3: A round entry holding zero passes the accumulator to the window logic unchanged.
- R4: A window entry w (bits 4:0 of the written word) outputs sum bits [w+11:w]; any w above 20 behaves as 20.
- R5: A limit entry holds the upper limit in bits 23:12 and the lower limit in bits 11:0; comparisons are unsigned on the 12-bit windowed value.
- R6: With clamping enabled, a value below the lower limit outputs the lower limit, a value above the upper limit outputs the upper limit, and any other value passes unchanged.
- R7: Clamping is enabled by bit 0 of the configuration word at address 0x005; while that bit is 0, the windowed value goes straight to `sample_o`.
- R8: In the vertical map (default), round entry n is at 0xA00+n, window entry n at 0x600+n and limit entry n at 0xE00+n; the horizontal map uses 0x800, 0x400 and 0xC00. A write to any other address changes no entry.
- R9: `sample_o` shows the result for an input three rising edges after that input is sampled. The result uses the entries and the enable bit that were valid on the input cycle. A write on that same edge, or on a later edge, does not affect it.
- R10: Reset clears every entry, the enable bit and the pipeline, so that `sample_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_i | input | 32 | Accumulator result from the filter |
| bank_sel_i | input | 4 | Bank index for this cycle's sample |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 12 | Register write address |
| wr_data_i | input | 32 | Register write data |
| sample_o | output | 12 | Rounded, windowed and clamped sample |

## Verification
The first stimulus sends random accumulator values through all-zero entries. This separates a correct window base from an offset add. Next, the sixteen banks are loaded with distinct rounds, windows and limits, and the selector is randomised on every cycle. This shows whether the round, window and limit entries are indexed together and per cycle, and window codes above 20 show whether the cap works. The clamp is then exercised both enabled and disabled, with values on both sides of each limit. Finally, writes to the horizontal map and to neighbouring addresses are mixed into the stream, and entries are rewritten while samples are still in flight. This shows that foreign addresses are ignored and that each sample keeps the settings of its own input cycle.

// File: rtl/rcw_pkg.sv
package rcw_pkg;

   typedef enum logic {
      RCW_PATH_VERT = 1'b0,
      RCW_PATH_HORZ = 1'b1
   } rcw_path_e;

   localparam int unsigned RCW_ADDR_W = 12;

   function automatic logic [RCW_ADDR_W-1:0] round_base(input rcw_path_e p);
      return (p == RCW_PATH_VERT) ? 12'hA00 : 12'h800;
   endfunction

   function automatic logic [RCW_ADDR_W-1:0] window_base(input rcw_path_e p);
      return (p == RCW_PATH_VERT) ? 12'h600 : 12'h400;
   endfunction

   function automatic logic [RCW_ADDR_W-1:0] limit_base(input rcw_path_e p);
      return (p == RCW_PATH_VERT) ? 12'hE00 : 12'hC00;
   endfunction

endpackage

// File: rtl/rcw_bank_file.sv
module rcw_bank_file #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IDX_W  = 4,
   parameter int unsigned ADDR_W = 12,
   parameter logic [ADDR_W-1:0] BASE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [DATA_W-1:0] rd_data_o
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   if (IDX_W >= ADDR_W) begin : g_bad_idx
      $error("rcw_bank_file: IDX_W must be smaller than ADDR_W");
   end
   if (BASE[IDX_W-1:0] != '0) begin : g_bad_base
      $error("rcw_bank_file: BASE must be aligned to the bank depth");
   end

   logic [DEPTH-1:0][DATA_W-1:0] mem_q;
   logic                         hit;

   assign hit = wr_en_i && (wr_addr_i[ADDR_W-1:IDX_W] == BASE[ADDR_W-1:IDX_W]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_q <= '0;
      end else if (hit) begin
         mem_q[wr_addr_i[IDX_W-1:0]] <= wr_data_i;
      end
   end

   assign rd_data_o = mem_q[rd_idx_i];

   // R8: an address outside this bank leaves every entry untouched
   p_foreign_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && (wr_addr_i[ADDR_W-1:IDX_W] != BASE[ADDR_W-1:IDX_W])) |=> $stable(mem_q));

endmodule

// File: rtl/rcw_window.sv
module rcw_window #(
   parameter int unsigned ACC_W  = 32,
   parameter int unsigned OUT_W  = 12,
   parameter int unsigned WSEL_W = 5,
   parameter int unsigned LIM_W  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ACC_W-1:0]  sum_i,
   input  logic [WSEL_W-1:0] sel_i,
   input  logic [LIM_W-1:0]  lim_i,
   input  logic              en_i,
   output logic [OUT_W-1:0]  win_o,
   output logic [LIM_W-1:0]  lim_o,
   output logic              en_o
);
   localparam int unsigned MAX_SHIFT = ACC_W - OUT_W;
   localparam int unsigned SEL_TOP   = (1 << WSEL_W) - 1;

   if (OUT_W > ACC_W) begin : g_bad_width
      $error("rcw_window: OUT_W may not exceed ACC_W");
   end

   logic [WSEL_W-1:0] shamt;
   logic [ACC_W-1:0]  shifted;

   if (MAX_SHIFT >= SEL_TOP) begin : g_nocap
      assign shamt = sel_i;
   end else begin : g_cap
      assign shamt = (sel_i > WSEL_W'(MAX_SHIFT)) ? WSEL_W'(MAX_SHIFT) : sel_i;
   end

   assign shifted = sum_i >> shamt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_o <= '0;
         lim_o <= '0;
         en_o  <= 1'b0;
      end else begin
         win_o <= shifted[OUT_W-1:0];
         lim_o <= lim_i;
         en_o  <= en_i;
      end
   end

   // R4: a zero window passes the low bits
   p_window_lsb_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i == '0) |=> (win_o == $past(sum_i[OUT_W-1:0])));

   // R4: a window past the top passes the most significant bits
   p_window_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(sel_i) >= MAX_SHIFT) |=> (win_o == $past(sum_i[ACC_W-1 -: OUT_W])));

endmodule

// File: rtl/rcw_clamp.sv
module rcw_clamp #(
   parameter int unsigned OUT_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [OUT_W-1:0]   val_i,
   input  logic [2*OUT_W-1:0] lim_i,
   input  logic               en_i,
   output logic [OUT_W-1:0]   out_o
);
   logic [OUT_W-1:0] lo, hi, res;

   assign lo = lim_i[OUT_W-1:0];
   assign hi = lim_i[2*OUT_W-1:OUT_W];

   always_comb begin
      res = val_i;
      if (en_i) begin
         if (val_i < lo)      res = lo;
         else if (val_i > hi) res = hi;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) out_o <= '0;
      else        out_o <= res;
   end

   // R6: below the lower limit yields the lower limit
   p_clamp_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && (val_i < lo) && (lo < hi)) |=> (out_o == $past(lo)));

   // R6: above the upper limit yields the upper limit
   p_clamp_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && (val_i > hi) && (lo < hi)) |=> (out_o == $past(hi)));

   // R7: with clamping off the value is passed as is
   p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i) |=> (out_o == $past(val_i)));

endmodule

// File: rtl/rcw_output_stage.sv
module rcw_output_stage
   import rcw_pkg::*;
#(
   parameter int unsigned ACC_W    = 32,
   parameter int unsigned OUT_W    = 12,
   parameter int unsigned SEL_W    = 4,
   parameter int unsigned WSEL_W   = 5,
   parameter rcw_path_e   PATH     = RCW_PATH_VERT,
   parameter logic [11:0] CFG_ADDR = 12'h005
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ACC_W-1:0]      acc_i,
   input  logic [SEL_W-1:0]      bank_sel_i,
   input  logic                  wr_en_i,
   input  logic [RCW_ADDR_W-1:0] wr_addr_i,
   input  logic [ACC_W-1:0]      wr_data_i,
   output logic [OUT_W-1:0]      sample_o
);
   localparam int unsigned LIM_W = 2 * OUT_W;

   if (LIM_W > ACC_W) begin : g_bad_lim
      $error("rcw_output_stage: limit pair must fit in the write word");
   end
   if (WSEL_W > ACC_W) begin : g_bad_wsel
      $error("rcw_output_stage: window code must fit in the write word");
   end

   logic [RCW_ADDR_W-1:0] base_round, base_win, base_lim;

   if (PATH == RCW_PATH_VERT) begin : g_vert
      assign base_round = round_base(RCW_PATH_VERT);
      assign base_win   = window_base(RCW_PATH_VERT);
      assign base_lim   = limit_base(RCW_PATH_VERT);
   end else begin : g_horz
      assign base_round = round_base(RCW_PATH_HORZ);
      assign base_win   = window_base(RCW_PATH_HORZ);
      assign base_lim   = limit_base(RCW_PATH_HORZ);
   end

   logic [ACC_W-1:0]  round_rd;
   logic [WSEL_W-1:0] win_rd;
   logic [LIM_W-1:0]  lim_rd;
   logic              clamp_en_q;

   rcw_bank_file #(.DATA_W(ACC_W), .IDX_W(SEL_W), .ADDR_W(RCW_ADDR_W),
                   .BASE(round_base(PATH))) u_round (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i), .rd_idx_i(bank_sel_i), .rd_data_o(round_rd));

   rcw_bank_file #(.DATA_W(WSEL_W), .IDX_W(SEL_W), .ADDR_W(RCW_ADDR_W),
                   .BASE(window_base(PATH))) u_window (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i[WSEL_W-1:0]), .rd_idx_i(bank_sel_i), .rd_data_o(win_rd));

   rcw_bank_file #(.DATA_W(LIM_W), .IDX_W(SEL_W), .ADDR_W(RCW_ADDR_W),
                   .BASE(limit_base(PATH))) u_limit (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i[LIM_W-1:0]), .rd_idx_i(bank_sel_i), .rd_data_o(lim_rd));

   // configuration word: bit 0 enables clamping
   always_ff @(posedge clk) begin
      if (!rst_n)                                 clamp_en_q <= 1'b0;
      else if (wr_en_i && wr_addr_i == CFG_ADDR)  clamp_en_q <= wr_data_i[0];
   end

   // stage 1: add round value, capture this sample's settings
   logic [ACC_W-1:0]  s1_sum;
   logic [WSEL_W-1:0] s1_win;
   logic [LIM_W-1:0]  s1_lim;
   logic              s1_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_sum <= '0;
         s1_win <= '0;
         s1_lim <= '0;
         s1_en  <= 1'b0;
      end else begin
         s1_sum <= acc_i + round_rd;
         s1_win <= win_rd;
         s1_lim <= lim_rd;
         s1_en  <= clamp_en_q;
      end
   end

   // R1/R3: the sum register holds accumulator plus selected round value
   p_add_r1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (s1_sum - $past(acc_i) == $past(round_rd)));

   // stage 2: window extraction
   logic [OUT_W-1:0] s2_val;
   logic [LIM_W-1:0] s2_lim;
   logic             s2_en;

   rcw_window #(.ACC_W(ACC_W), .OUT_W(OUT_W), .WSEL_W(WSEL_W), .LIM_W(LIM_W)) u_win (
      .clk(clk), .rst_n(rst_n), .sum_i(s1_sum), .sel_i(s1_win), .lim_i(s1_lim),
      .en_i(s1_en), .win_o(s2_val), .lim_o(s2_lim), .en_o(s2_en));

   // stage 3: clamp
   rcw_clamp #(.OUT_W(OUT_W)) u_clamp (
      .clk(clk), .rst_n(rst_n), .val_i(s2_val), .lim_i(s2_lim), .en_i(s2_en),
      .out_o(sample_o));

   // R10: reset leaves the output at zero on the following cycle
   p_reset_out_r10: assert property (@(posedge clk)
      (!rst_n) |=> (sample_o == '0));

endmodule

// File: tb/rcw_output_stage_tb.sv
module rcw_output_stage_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] acc_i = '0;
   logic [3:0]  bank_sel_i = '0;
   logic        wr_en_i = 1'b0;
   logic [11:0] wr_addr_i = '0;
   logic [31:0] wr_data_i = '0;
   logic [11:0] sample_o;

   always #10 clk = ~clk;   // 50 MHz

   rcw_output_stage dut_i (
      .clk(clk), .rst_n(rst_n), .acc_i(acc_i), .bank_sel_i(bank_sel_i),
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .sample_o(sample_o));

   int    n_checks = 0;
   int    n_fail   = 0;
   string cur_tag  = "R10";
   bit    done     = 1'b0;

   // behavioural model state
   logic [31:0] m_round [16];
   logic [4:0]  m_win   [16];
   logic [23:0] m_lim   [16];
   bit          m_en;
   logic [11:0] pipe [$];

   function automatic logic [11:0] model_out(input logic [31:0] acc, input int sel);
      logic [31:0] s;
      int          w;
      logic [11:0] v, lo, hi;
      s  = acc + m_round[sel];
      w  = int'(m_win[sel]);
      if (w > 20) w = 20;
      v  = 12'((s >> w) & 32'hFFF);
      lo = m_lim[sel][11:0];
      hi = m_lim[sel][23:12];
      if (m_en) begin
         if (v < lo)      v = lo;
         else if (v > hi) v = hi;
      end
      return v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) begin
            m_round[i] = '0; m_win[i] = '0; m_lim[i] = '0;
         end
         m_en = 1'b0;
         pipe.delete();
         for (int i = 0; i < 3; i++) pipe.push_back(12'h000);
      end else begin
         pipe.push_back(model_out(acc_i, int'(bank_sel_i)));
         void'(pipe.pop_front());
         if (wr_en_i) begin
            if (wr_addr_i >= 12'hA00 && wr_addr_i <= 12'hA0F) m_round[wr_addr_i[3:0]] = wr_data_i;
            if (wr_addr_i >= 12'h600 && wr_addr_i <= 12'h60F) m_win[wr_addr_i[3:0]] = wr_data_i[4:0];
            if (wr_addr_i >= 12'hE00 && wr_addr_i <= 12'hE0F) m_lim[wr_addr_i[3:0]] = wr_data_i[23:0];
            if (wr_addr_i == 12'h005) m_en = wr_data_i[0];
         end
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done && pipe.size() == 3) begin
         n_checks++;
         if (sample_o !== pipe[0]) begin
            n_fail++;
            $display("FAIL %s: sample_o=%h expected=%h at %0t", cur_tag, sample_o, pipe[0], $time);
         end
      end
   end

   task automatic cyc(input logic [31:0] acc, input logic [3:0] sel,
                      input bit wr = 0, input logic [11:0] a = '0, input logic [31:0] d = '0);
      @(negedge clk);
      acc_i = acc; bank_sel_i = sel;
      wr_en_i = wr; wr_addr_i = a; wr_data_i = d;
   endtask

   task automatic rnd_cycles(input int n);
      for (int i = 0; i < n; i++) cyc($urandom, 4'($urandom));
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10: output is zero in reset
      n_checks++;
      if (sample_o !== 12'h000) begin
         n_fail++;
         $display("FAIL R10: sample_o=%h expected=000", sample_o);
      end
      rst_n = 1'b1;
      cur_tag = "R10";
      rnd_cycles(3);

      // R3: zero rounds and zero windows pass acc bits [11:0]
      cur_tag = "R3";
      rnd_cycles(40);

      // R1, R2, R4: distinct rounds and windows, selector random each cycle
      cur_tag = "R1";
      for (int i = 0; i < 16; i++) cyc($urandom, 4'($urandom), 1, 12'hA00 + 12'(i), $urandom);
      cur_tag = "R4";
      for (int i = 0; i < 16; i++) cyc($urandom, 4'($urandom), 1, 12'h600 + 12'(i), 32'(i + 8));
      cur_tag = "R2";
      rnd_cycles(200);
      // R1: half-LSB round on window 4 and wrap of the 32-bit add
      cur_tag = "R1";
      cyc(32'h0, 4'd0, 1, 12'h600, 32'd4);
      cyc(32'h0, 4'd0, 1, 12'hA00, 32'h8);
      cyc(32'h0, 4'd1, 1, 12'hA01, 32'hFFFF_FFFF);
      for (int i = 0; i < 30; i++) cyc($urandom, 4'($urandom % 2));
      cyc(32'h0000_0017, 4'd0);
      cyc(32'h0000_0005, 4'd1);

      // R4: window codes above 20, including 31
      cur_tag = "R4";
      cyc($urandom, 4'd0, 1, 12'h603, 32'd21);
      cyc($urandom, 4'd0, 1, 12'h604, 32'd31);
      cyc($urandom, 4'd0, 1, 12'h605, 32'd20);
      for (int i = 0; i < 60; i++) cyc($urandom, 4'(3 + $urandom % 3));

      // R5, R6: limits and clamp enable
      cur_tag = "R5";
      for (int i = 0; i < 16; i++) begin
         int lo, hi;
         lo = int'($urandom % 2048);
         hi = lo + 1 + int'($urandom % (4094 - lo));
         cyc($urandom, 4'($urandom), 1, 12'hE00 + 12'(i), 32'((hi << 12) | lo));
      end
      cur_tag = "R6";
      cyc($urandom, 4'($urandom), 1, 12'h005, 32'h1);
      rnd_cycles(300);

      // R7: clamp disabled, then toggled
      cur_tag = "R7";
      cyc($urandom, 4'($urandom), 1, 12'h005, 32'hFFFF_FFFE);
      rnd_cycles(100);
      cyc($urandom, 4'($urandom), 1, 12'h005, 32'h1);
      rnd_cycles(20);

      // R8: horizontal-map and neighbouring addresses are ignored
      cur_tag = "R8";
      for (int i = 0; i < 16; i++) begin
         cyc($urandom, 4'($urandom), 1, 12'h800 + 12'(i), $urandom);
         cyc($urandom, 4'($urandom), 1, 12'h400 + 12'(i), $urandom);
         cyc($urandom, 4'($urandom), 1, 12'hC00 + 12'(i), $urandom);
      end
      cyc($urandom, 4'($urandom), 1, 12'hA10, $urandom);
      cyc($urandom, 4'($urandom), 1, 12'h9FF, $urandom);
      cyc($urandom, 4'($urandom), 1, 12'hE10, $urandom);
      cyc($urandom, 4'($urandom), 1, 12'h004, 32'h0);
      rnd_cycles(80);

      // R9: rewrite entries while their samples are in flight
      cur_tag = "R9";
      for (int i = 0; i < 300; i++) begin
         logic [3:0] s;
         s = 4'($urandom);
         case ($urandom % 4)
            0: cyc($urandom, s, 1, 12'hA00 + 12'(s), $urandom);
            1: cyc($urandom, s, 1, 12'h600 + 12'(s), $urandom);
            2: cyc($urandom, s, 1, 12'h005, $urandom);
            default: cyc($urandom, s);
         endcase
      end
      rnd_cycles(5);

      // R10: reset mid-stream clears entries and output
      cur_tag = "R10";
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      n_checks++;
      if (sample_o !== 12'h000) begin
         n_fail++;
         $display("FAIL R10: sample_o=%h expected=000 after reset", sample_o);
      end
      rst_n = 1'b1;
      rnd_cycles(30);

      finish_run();
   end

endmodule